// File: doc/BRIEF.md
# Cross-Clock CPU Event Pulse Generator

This block moves a CPU event request out of the system-clock domain and into the free-running CPU clock domain. The request input is the OR of every event line, and it is synchronous to the system clock. In the system domain, a rising edge on that request raises a level flag. In the CPU domain, the flag passes through a synchronizer and an edge detector, which turn it into an event pulse one CPU cycle wide.

In the same cycle as the pulse, the CPU domain drives a clearing signal. This signal asynchronously resets the system-domain flag, and it stays high until the synchronized flag reads low. That closes the handshake, and no pending state is left behind.

A request edge can arrive while a handshake is still running. Such an edge is stored in a one-bit catch register and is sent once the clear has finished. Any further edges that arrive in that window merge into the stored one. The flag and the clearing signal are brought out so they can be observed.

Top module: `cpu_evt_xfer`

## Requirements
- R1: While either reset is asserted, and right after it is released, the pulse, flag and clear outputs are all 0.
- R2: A rising edge of the request, sampled at a system clock edge while the transfer is idle, sets the flag (1 = event waiting) at that edge. The result is exactly one CPU pulse per launched flag.
- R3: Every event pulse is high for exactly one CPU clock cycle.
- R4: The clear output rises in the same CPU cycle as the pulse and is held until the synchronized flag reads 0. While the clear is high, the flag output is 0.
- R5: Request edges that arrive while a handshake is in progress are merged into one stored request. That request produces exactly one more pulse after the clear has completed.
- R6: A request held high, or a falling edge of the request, produces no pulse beyond the one for its rising edge.
- R7: With the CPU clock faster than, equal to or slower than the system clock, no expected pulse is lost and none is duplicated.
- R8: Once a handshake is complete and no request is stored, the flag and the clear both return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset of the system domain |
| cpu_clk | input | 1 | Free-running CPU clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset of the CPU domain |
| evt_req_i | input | 1 | OR of all event requests, synchronous to sys_clk |
| evt_pulse_o | output | 1 | One-cycle event pulse, synchronous to cpu_clk |
| evt_flag_o | output | 1 | Level event flag in the system domain |
| evt_clr_o | output | 1 | Flag clearing signal, synchronous to cpu_clk |

## Verification
The assertions assume that the request input changes only away from system clock edges. They also assume that both clocks run continuously, so that the synchronizers settle within their stage count. The stimulus drives the request on falling system clock edges. It runs three fixed CPU/system period ratios, and it changes a ratio only while the transfer is idle. The checks therefore never see a clock change in the middle of a handshake.

// File: rtl/cpu_evt_pkg.sv
package cpu_evt_pkg;

  // System-side handshake phases
  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_WAIT_CLR = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;

endpackage

// File: rtl/cpu_evt_sync.sv
module cpu_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cpu_evt_src.sv
module cpu_evt_src
  import cpu_evt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic flag_o
);

  localparam int CNT_W = $clog2(STAGES + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STAGES);

  src_state_e       state_q, state_d;
  logic             req_q;
  logic             catch_q, catch_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q;
  logic             clr_sync;
  logic             rise;
  logic             launch;
  logic             flag_rst_n;

  cpu_evt_sync #(.STAGES(STAGES)) u_clr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (clr_i),
    .q_o   (clr_sync)
  );

  assign rise   = req_i & ~req_q;
  assign launch = (state_q == SRC_IDLE) & (rise | catch_q);

  always_comb begin
    state_d = state_q;
    catch_d = catch_q;
    cnt_d   = cnt_q;
    case (state_q)
      SRC_IDLE: begin
        catch_d = 1'b0;
        cnt_d   = '0;
        if (launch) state_d = SRC_WAIT_CLR;
      end
      SRC_WAIT_CLR: begin
        catch_d = catch_q | rise;
        if (!flag_q) state_d = SRC_WAIT_REL;
      end
      SRC_WAIT_REL: begin
        catch_d = catch_q | rise;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        else if (!clr_sync)   state_d = SRC_IDLE;
      end
      default: state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      catch_q <= 1'b0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      catch_q <= catch_d;
      cnt_q   <= cnt_d;
      req_q   <= req_i;
    end
  end

  // Flag: set by launch, cleared asynchronously from the CPU domain
  assign flag_rst_n = rst_n & ~clr_i;

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n)  flag_q <= 1'b0;
    else if (launch)  flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/cpu_evt_dst.sv
module cpu_evt_dst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic pulse_o,
  output logic clr_o
);

  logic flag_sync;
  logic clr_q, clr_d;
  logic pulse_q, pulse_d;

  cpu_evt_sync #(.STAGES(STAGES)) u_flag_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flag_i),
    .q_o   (flag_sync)
  );

  always_comb begin
    clr_d   = clr_q;
    pulse_d = 1'b0;
    if (!clr_q && flag_sync) begin
      clr_d   = 1'b1;
      pulse_d = 1'b1;
    end else if (clr_q && !flag_sync) begin
      clr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      clr_q   <= clr_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign clr_o   = clr_q;

endmodule

// File: rtl/cpu_evt_xfer.sv
module cpu_evt_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic cpu_clk,
  input  logic cpu_rst_n,
  input  logic evt_req_i,
  output logic evt_pulse_o,
  output logic evt_flag_o,
  output logic evt_clr_o
);

  logic sys_rst_sync_n;
  logic cpu_rst_sync_n;
  logic flag;
  logic clr;

  // Asynchronous assert, synchronous release per domain
  cpu_evt_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .d_i   (1'b1),
    .q_o   (sys_rst_sync_n)
  );

  cpu_evt_sync #(.STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk   (cpu_clk),
    .rst_n (cpu_rst_n),
    .d_i   (1'b1),
    .q_o   (cpu_rst_sync_n)
  );

  cpu_evt_src #(.STAGES(SYNC_STAGES)) u_src (
    .clk    (sys_clk),
    .rst_n  (sys_rst_sync_n),
    .req_i  (evt_req_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  cpu_evt_dst #(.STAGES(SYNC_STAGES)) u_dst (
    .clk     (cpu_clk),
    .rst_n   (cpu_rst_sync_n),
    .flag_i  (flag),
    .pulse_o (evt_pulse_o),
    .clr_o   (clr)
  );

  assign evt_flag_o = flag;
  assign evt_clr_o  = clr;

endmodule

// File: rtl/cpu_evt_xfer_chk.sv
module cpu_evt_xfer_chk (
  input logic sys_clk,
  input logic sys_rst_n,
  input logic cpu_clk,
  input logic cpu_rst_n,
  input logic evt_pulse_o,
  input logic evt_flag_o,
  input logic evt_clr_o
);

  AST_PULSE_SINGLE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    evt_pulse_o |=> !evt_pulse_o); // R3

  AST_PULSE_WITH_CLEAR: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    evt_pulse_o |-> evt_clr_o); // R4

  AST_CLEAR_RISES_WITH_PULSE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $rose(evt_clr_o) |-> evt_pulse_o); // R4

  AST_NO_PULSE_WHILE_CLEAR_HELD: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (evt_clr_o && $past(evt_clr_o)) |-> !evt_pulse_o); // R2

  AST_FLAG_LOW_UNDER_CLEAR: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    evt_clr_o |-> !evt_flag_o); // R4

endmodule

bind cpu_evt_xfer cpu_evt_xfer_chk u_chk (
  .sys_clk     (sys_clk),
  .sys_rst_n   (sys_rst_n),
  .cpu_clk     (cpu_clk),
  .cpu_rst_n   (cpu_rst_n),
  .evt_pulse_o (evt_pulse_o),
  .evt_flag_o  (evt_flag_o),
  .evt_clr_o   (evt_clr_o)
);

// File: tb/cpu_evt_xfer_tb_top.sv
`timescale 1ns/1ps
module cpu_evt_xfer_tb_top;

  logic sys_clk = 1'b0;
  logic cpu_clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic cpu_rst_n = 1'b0;
  logic evt_req_i = 1'b0;
  logic evt_pulse_o, evt_flag_o, evt_clr_o;

  realtime cpu_half = 2.5;
  int checks = 0;
  int errors = 0;
  int phase = 0;
  bit mon_en = 1'b0;
  bit prev_pulse = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  cpu_evt_xfer dut_i (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .cpu_clk     (cpu_clk),
    .cpu_rst_n   (cpu_rst_n),
    .evt_req_i   (evt_req_i),
    .evt_pulse_o (evt_pulse_o),
    .evt_flag_o  (evt_flag_o),
    .evt_clr_o   (evt_clr_o)
  );

  always #2.5 sys_clk = ~sys_clk;
  initial forever #(cpu_half) cpu_clk = ~cpu_clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", r, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per observed pulse
  always @(negedge cpu_clk) begin
    if (mon_en) begin
      if (evt_pulse_o) begin
        chk(!prev_pulse, "R3 pulse width", 2, 1);
        chk(evt_clr_o, "R4 clear with pulse", evt_clr_o, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected pulse", 1, 0);
        end else begin
          int tag;
          tag = exp_q.pop_front();
          chk(tag == phase, "R7 pulse phase", tag, phase);
        end
      end
      prev_pulse = evt_pulse_o;
    end
  end

  task automatic idle_wait(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  // Driver: isolated edge, flag observed one cycle later
  task automatic send_edge();
    @(negedge sys_clk);
    evt_req_i = 1'b1;
    exp_q.push_back(phase);
    @(negedge sys_clk);
    chk(evt_flag_o, "R2 flag set by edge", evt_flag_o, 1);
    evt_req_i = 1'b0;
    idle_wait(60);
  endtask

  // Three edges back to back: one launch plus one merged stored request
  task automatic send_burst();
    @(negedge sys_clk);
    evt_req_i = 1'b1;
    exp_q.push_back(phase);
    exp_q.push_back(phase);
    @(negedge sys_clk); evt_req_i = 1'b0;
    @(negedge sys_clk); evt_req_i = 1'b1;
    @(negedge sys_clk); evt_req_i = 1'b0;
    @(negedge sys_clk); evt_req_i = 1'b1;
    @(negedge sys_clk); evt_req_i = 1'b0;
    idle_wait(120);
    chk(exp_q.size() == 0, "R5 burst pulses", exp_q.size(), 0);
  endtask

  task automatic send_held();
    @(negedge sys_clk);
    evt_req_i = 1'b1;
    exp_q.push_back(phase);
    idle_wait(100);
    evt_req_i = 1'b0;
    idle_wait(60);
    chk(exp_q.size() == 0, "R6 held request single pulse", exp_q.size(), 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_wait(4);
    chk(!evt_pulse_o && !evt_flag_o && !evt_clr_o, "R1 outputs in reset",
        {evt_pulse_o, evt_flag_o, evt_clr_o}, 0);
    sys_rst_n = 1'b1;
    cpu_rst_n = 1'b1;
    idle_wait(12);
    chk(!evt_pulse_o && !evt_flag_o && !evt_clr_o, "R1 outputs after reset",
        {evt_pulse_o, evt_flag_o, evt_clr_o}, 0);
    mon_en = 1'b1;
    for (int p = 0; p < 3; p++) begin
      phase = p;
      cpu_half = (p == 0) ? 1.5 : (p == 1) ? 2.5 : 6.5;
      idle_wait(10);
      for (int k = 0; k < 3; k++) send_edge();
      chk(exp_q.size() == 0, "R7 isolated pulses", exp_q.size(), 0);
      send_burst();
      send_held();
      chk(!evt_flag_o, "R8 flag idle", evt_flag_o, 0);
      chk(!evt_clr_o, "R8 clear idle", evt_clr_o, 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule